// File: doc/BRIEF.md
# Flash Block Lock-Bit Controller

This block is the protection corner of a byte-wide flash command interface. It keeps one lock bit for each erase block and one master lock bit above them. Software sets a lock by writing two bus cycles: a setup byte, then a confirm byte. The confirm byte chooses between locking the block named by the confirm address and locking the whole set of block locks through the master bit. An accepted sequence starts a timed operation. During that operation the block reports busy and stalls further writes. When the operation ends, the block commits the new lock or records why the operation failed.

Two digital qualifiers decide the outcome: a high-voltage flag on the reset pin and a supply-valid flag. The block samples both on the cycle the confirm write is accepted. When the master bit is clear, block locks need no qualifier. When the master bit is set, block locks and master locks both need the high-voltage flag. The status byte reports readiness and sticky error bits. A lookup port tells the program and erase logic whether a given block may be written.

Bus writes use a valid/ready handshake. A write transfers on a clock edge where `wr_valid_i` and `wr_ready_o` are both high. `wr_ready_o` stays low for the whole busy window. The master must hold address and data steady until the transfer takes place. No write is dropped, and none is taken while the block is busy.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset the status byte is 0x80, `ready_busy_o` and `wr_ready_o` are 1, `read_status_o` is 0, the master lock is clear and every block reads as writable.
- R2: The sequence 0x60 then 0x01 makes `ready_busy_o`, status bit 7 and `wr_ready_o` low for exactly BUSY_CYCLES clock cycles after the confirm edge. On success it then locks the block given by the top log2(NUM_BLOCKS) bits of the confirm address.
- R3: While the master lock is clear, a block lock succeeds with the high-voltage flag low, and the status ends at 0x80.
- R4: While the master lock is set, a block lock succeeds only with the high-voltage flag high. Otherwise no lock changes and status bits 1 and 4 are set (status 0x92).
- R5: The sequence 0x60 then 0xF1, at any address, sets the master lock only with the high-voltage flag high. Otherwise the master lock stays clear and the status becomes 0x92.
- R6: After 0x60, a confirm byte other than 0x01 or 0xF1 starts no busy window, changes no lock and sets status bits 4 and 5 (status 0xB0).
- R7: With the supply-valid flag low, an accepted sequence changes no lock and sets status bits 3 and 4 (status 0x98).
- R8: `read_status_o` goes to 1 after the setup byte, the confirm byte or 0x70, and stays 1 until 0xFF is written, which sets it to 0.
- R9: Status bits 1, 3, 4 and 5 hold through later commands until 0x50 is written outside a sequence, which clears them.
- R10: `blk_writable_o` is the inverse of the lock bit of block `query_blk_i`. Lock bits and the master lock never clear except by reset, and they change only on the cycle a busy window ends.
- R11: The two qualifiers are sampled on the confirm edge. Changing them during the busy window does not change the outcome.
- R12: Status bits 0, 2 and 6 always read 0. Outside a sequence, bytes other than 0x60, 0x50, 0x70 and 0xFF have no effect on the status or the read mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid_i | input | 1 | Bus write request |
| wr_ready_o | output | 1 | Write accepted this edge when high with valid |
| wr_addr_i | input | ADDR_W | Write address; the top bits select the block |
| wr_data_i | input | 8 | Command byte |
| hv_flag_i | input | 1 | Reset pin at high-voltage level |
| supply_ok_i | input | 1 | Program supply within range |
| query_blk_i | input | log2(NUM_BLOCKS) | Block to look up |
| blk_writable_o | output | 1 | Queried block may be programmed or erased |
| master_lock_o | output | 1 | Master lock bit |
| ready_busy_o | output | 1 | 1 when idle, 0 during an operation |
| read_status_o | output | 1 | Reads return the status byte when 1 |
| status_o | output | 8 | Status byte |

## Verification
A corrupted lock bit shows up at once on `blk_writable_o` for that block. It also shows up on the next busy window through a permission result that differs from the expected one. A wrong command state appears on the next accepted write as a missing busy window, an unexpected 0xB0 status or a stale read mode. A miscounted timer moves the rising edge of `ready_busy_o` away from its fixed cycle after the confirm edge. The bench therefore samples that edge exactly, and it sweeps every combination of master state, qualifier pair and confirm kind against outcomes computed from these rules.

// File: rtl/flash_lock_pkg.sv
package flash_lock_pkg;
  localparam logic [7:0] CMD_LOCK_SETUP  = 8'h60;
  localparam logic [7:0] CMD_CONF_BLOCK  = 8'h01;
  localparam logic [7:0] CMD_CONF_MASTER = 8'hF1;
  localparam logic [7:0] CMD_CLR_STATUS  = 8'h50;
  localparam logic [7:0] CMD_RD_STATUS   = 8'h70;
  localparam logic [7:0] CMD_RD_ARRAY    = 8'hFF;

  typedef enum logic [1:0] {
    MODE_ARRAY  = 2'd0,
    MODE_STATUS = 2'd1,
    MODE_SETUP  = 2'd2,
    MODE_BUSY   = 2'd3
  } mode_e;

  typedef struct packed {
    logic to_master;
    logic hv;
    logic sup;
  } lock_op_t;
endpackage

// File: rtl/flash_lock_timer.sv
module flash_lock_timer #(
  parameter int BUSY_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD = CNT_W'(BUSY_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (start_i) cnt_q <= LOAD;
    else if (cnt_q != '0) cnt_q <= cnt_q - LAST;
  end

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == LAST);
endmodule

// File: rtl/flash_lock_cmd.sv
module flash_lock_cmd
  import flash_lock_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              hv_i,
  input  logic              sup_i,
  input  logic              done_i,
  output logic              wr_ready_o,
  output logic              read_status_o,
  output logic              start_o,
  output logic              seq_err_o,
  output logic              clr_o,
  output lock_op_t          op_o,
  output logic [BLK_W-1:0]  op_blk_o
);
  mode_e            mode_q, mode_d;
  lock_op_t         op_q, op_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             fire;
  logic             unused_addr;

  assign unused_addr = ^wr_addr_i;
  assign wr_ready_o  = (mode_q != MODE_BUSY);
  assign fire        = wr_valid_i && wr_ready_o;

  always_comb begin
    mode_d    = mode_q;
    op_d      = op_q;
    blk_d     = blk_q;
    start_o   = 1'b0;
    seq_err_o = 1'b0;
    clr_o     = 1'b0;
    case (mode_q)
      MODE_BUSY: if (done_i) mode_d = MODE_STATUS;
      MODE_SETUP: if (fire) begin
        if (wr_data_i == CMD_CONF_BLOCK || wr_data_i == CMD_CONF_MASTER) begin
          op_d.to_master = (wr_data_i == CMD_CONF_MASTER);
          op_d.hv        = hv_i;
          op_d.sup       = sup_i;
          blk_d          = wr_addr_i[ADDR_W-1 -: BLK_W];
          start_o        = 1'b1;
          mode_d         = MODE_BUSY;
        end else begin
          seq_err_o = 1'b1;
          mode_d    = MODE_STATUS;
        end
      end
      default: if (fire) begin
        case (wr_data_i)
          CMD_LOCK_SETUP: mode_d = MODE_SETUP;
          CMD_CLR_STATUS: clr_o  = 1'b1;
          CMD_RD_STATUS:  mode_d = MODE_STATUS;
          CMD_RD_ARRAY:   mode_d = MODE_ARRAY;
          default:        mode_d = mode_q;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_ARRAY;
      op_q   <= '0;
      blk_q  <= '0;
    end else begin
      mode_q <= mode_d;
      op_q   <= op_d;
      blk_q  <= blk_d;
    end
  end

  assign read_status_o = (mode_q != MODE_ARRAY);
  assign op_o          = op_q;
  assign op_blk_o      = blk_q;
endmodule

// File: rtl/flash_lock_store.sv
module flash_lock_store
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS = 8,
  parameter int BLK_W      = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done_i,
  input  lock_op_t              op_i,
  input  logic [BLK_W-1:0]      op_blk_i,
  input  logic                  seq_err_i,
  input  logic                  clr_i,
  output logic [NUM_BLOCKS-1:0] lock_o,
  output logic                  master_o,
  output logic                  err_prot_o,
  output logic                  err_sup_o,
  output logic                  err_lock_o,
  output logic                  err_seq_o
);
  logic master_q;
  logic sup_fail, prot_fail, grant;

  assign sup_fail  = !op_i.sup;
  assign prot_fail = op_i.sup && !op_i.hv && (op_i.to_master || master_q);
  assign grant     = done_i && !sup_fail && !prot_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) master_q <= 1'b0;
    else if (grant && op_i.to_master) master_q <= 1'b1;
  end

  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_blk
    logic lk_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lk_q <= 1'b0;
      else if (grant && !op_i.to_master && op_blk_i == BLK_W'(b)) lk_q <= 1'b1;
    end
    assign lock_o[b] = lk_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_prot_o <= 1'b0;
      err_sup_o  <= 1'b0;
      err_lock_o <= 1'b0;
      err_seq_o  <= 1'b0;
    end else if (clr_i) begin
      err_prot_o <= 1'b0;
      err_sup_o  <= 1'b0;
      err_lock_o <= 1'b0;
      err_seq_o  <= 1'b0;
    end else begin
      if (done_i && prot_fail) err_prot_o <= 1'b1;
      if (done_i && sup_fail)  err_sup_o  <= 1'b1;
      if ((done_i && (sup_fail || prot_fail)) || seq_err_i) err_lock_o <= 1'b1;
      if (seq_err_i) err_seq_o <= 1'b1;
    end
  end

  assign master_o = master_q;
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
  import flash_lock_pkg::*;
#(
  parameter int NUM_BLOCKS  = 8,
  parameter int ADDR_W      = 8,
  parameter int BUSY_CYCLES = 4,
  localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid_i,
  output logic              wr_ready_o,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              hv_flag_i,
  input  logic              supply_ok_i,
  input  logic [BLK_W-1:0]  query_blk_i,
  output logic              blk_writable_o,
  output logic              master_lock_o,
  output logic              ready_busy_o,
  output logic              read_status_o,
  output logic [7:0]        status_o
);
  lock_op_t              op;
  logic [BLK_W-1:0]      op_blk;
  logic                  start, done, busy, seq_err, clr;
  logic [NUM_BLOCKS-1:0] lock_vec;
  logic                  e_prot, e_sup, e_lock, e_seq;

  flash_lock_cmd #(.ADDR_W(ADDR_W), .BLK_W(BLK_W)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .hv_i(hv_flag_i), .sup_i(supply_ok_i), .done_i(done),
    .wr_ready_o(wr_ready_o), .read_status_o(read_status_o), .start_o(start),
    .seq_err_o(seq_err), .clr_o(clr), .op_o(op), .op_blk_o(op_blk)
  );

  flash_lock_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done)
  );

  flash_lock_store #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_store (
    .clk(clk), .rst_n(rst_n), .done_i(done), .op_i(op), .op_blk_i(op_blk),
    .seq_err_i(seq_err), .clr_i(clr), .lock_o(lock_vec), .master_o(master_lock_o),
    .err_prot_o(e_prot), .err_sup_o(e_sup), .err_lock_o(e_lock), .err_seq_o(e_seq)
  );

  assign ready_busy_o   = !busy;
  assign blk_writable_o = !lock_vec[query_blk_i];
  assign status_o       = {!busy, 1'b0, e_seq, e_lock, e_sup, 1'b0, e_prot, 1'b0};
endmodule

// File: rtl/flash_lock_chk.sv
module flash_lock_chk #(
  parameter int NUM_BLOCKS  = 8,
  parameter int ADDR_W      = 8,
  parameter int BLK_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [7:0]        wr_data_i,
  input logic              hv_flag_i,
  input logic              supply_ok_i,
  input logic [BLK_W-1:0]  query_blk_i,
  input logic              blk_writable_o,
  input logic              master_lock_o,
  input logic              ready_busy_o,
  input logic              read_status_o,
  input logic [7:0]        status_o
);
  logic clr_fire;
  logic unused_chk;
  assign clr_fire   = wr_valid_i && wr_ready_o && (wr_data_i == 8'h50);
  assign unused_chk = ^{wr_addr_i, hv_flag_i, supply_ok_i, query_blk_i, blk_writable_o};

  // R2: a busy block takes no write
  a_r2_stall_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_busy_o |-> !wr_ready_o);

  // R8: status reads stay selected through the busy window
  a_r8_status_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !ready_busy_o |-> read_status_o);

  // R9: error bits are sticky until a clear command
  a_r9_lock_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[4] && !clr_fire) |=> status_o[4]);
  a_r9_seq_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[5] && !clr_fire) |=> status_o[5]);

  // R10: master lock never clears and moves only when a busy window ends
  a_r10_master_hold: assert property (@(posedge clk) disable iff (!rst_n)
    master_lock_o |=> master_lock_o);
  a_r10_master_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(master_lock_o) |-> $rose(ready_busy_o));

  // R12: reserved status bits read zero
  a_r12_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[6] == 1'b0) && (status_o[2] == 1'b0) && (status_o[0] == 1'b0));
endmodule

bind flash_lock_ctrl flash_lock_chk #(
  .NUM_BLOCKS(NUM_BLOCKS), .ADDR_W(ADDR_W), .BLK_W(BLK_W)
) u_chk (.*);

// File: tb/tb_flash_lock_ctrl.sv
`timescale 1ns/1ps
module tb_flash_lock_ctrl;
  localparam int NB    = 8;
  localparam int AW    = 8;
  localparam int BUSY  = 4;
  localparam int BW    = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic          wr_ready;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          hv = 1'b0;
  logic          sup = 1'b1;
  logic [BW-1:0] qblk = '0;
  logic          writable, master, ready, rd_stat;
  logic [7:0]    status;
  int            n_run = 0;
  int            n_fail = 0;

  always #2.5 clk = ~clk;

  flash_lock_ctrl #(.NUM_BLOCKS(NB), .ADDR_W(AW), .BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid), .wr_ready_o(wr_ready),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .hv_flag_i(hv), .supply_ok_i(sup),
    .query_blk_i(qblk), .blk_writable_o(writable), .master_lock_o(master),
    .ready_busy_o(ready), .read_status_o(rd_stat), .status_o(status)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_idle();
    while (!ready) @(negedge clk);
  endtask

  function automatic logic [7:0] blk_addr(input int b);
    return 8'((b << (AW - BW)) | 5);
  endfunction

  task automatic sweep_locks(input string req, input logic [NB-1:0] exp_lock);
    for (int b = 0; b < NB; b++) begin
      qblk = BW'(b); #0.1;
      check(req, writable, !exp_lock[b]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [NB-1:0] exp_lock;
    do_reset();
    @(negedge clk);
    // R1 reset state
    check("R1 status", status, 8'h80);
    check("R1 ready", ready, 1);
    check("R1 wr_ready", wr_ready, 1);
    check("R1 read mode", rd_stat, 0);
    check("R1 master", master, 0);
    sweep_locks("R1 writable", '0);

    // R12 unknown commands ignored; R8 read mode switching
    wr(8'h00, 8'h33);
    check("R12 unknown keeps array mode", rd_stat, 0);
    check("R12 unknown keeps status", status, 8'h80);
    wr(8'h00, 8'h70);
    check("R8 read status cmd", rd_stat, 1);
    wr(8'h00, 8'hFF);
    check("R8 read array cmd", rd_stat, 0);

    // R2 R3 R10: lock each block in turn with master clear, hv low
    exp_lock = '0;
    hv = 1'b0; sup = 1'b1;
    for (int b = 0; b < NB; b++) begin
      wr(blk_addr(b), 8'h60);
      check("R8 status after setup", rd_stat, 1);
      wr(blk_addr(b), 8'h01);
      for (int k = 0; k < BUSY; k++) begin
        check("R2 busy window", ready, 0);
        check("R2 stall", wr_ready, 0);
        check("R2 sr7 low", status[7], 0);
        @(negedge clk);
      end
      check("R2 ready after window", ready, 1);
      exp_lock[b] = 1'b1;
      check("R3 status", status, 8'h80);
      check("R8 stays status", rd_stat, 1);
      sweep_locks("R10 lock lookup", exp_lock);
    end

    // R6 invalid confirm, R9 sticky until clear
    wr(8'h00, 8'h60);
    wr(8'h00, 8'hA6);
    check("R6 no busy", ready, 1);
    check("R6 status", status, 8'hB0);
    sweep_locks("R6 locks unchanged", exp_lock);
    wr(8'h00, 8'h70);
    wr(8'h00, 8'hFF);
    wr(8'h00, 8'h33);
    check("R9 sticky", status, 8'hB0);
    wr(8'h00, 8'h50);
    check("R9 cleared", status, 8'h80);

    // R4 R5 R7 sweep over master state, qualifiers and confirm kind
    for (int mp = 0; mp < 2; mp++)
      for (int h = 0; h < 2; h++)
        for (int s = 0; s < 2; s++)
          for (int km = 0; km < 2; km++) begin
            logic [7:0] exp_st;
            logic exp_m, exp_lk;
            do_reset();
            if (mp == 1) begin
              hv = 1'b1; sup = 1'b1;
              wr(8'h00, 8'h60); wr(8'h00, 8'hF1); wait_idle();
              wr(8'h00, 8'h50);
            end
            hv = h[0]; sup = s[0];
            wr(blk_addr(2), 8'h60);
            wr(blk_addr(2), (km == 1) ? 8'hF1 : 8'h01);
            wait_idle();
            exp_m = (mp == 1); exp_lk = 1'b0;
            if (s == 0) exp_st = 8'h98;
            else if (km == 1) begin
              exp_st = (h == 1) ? 8'h80 : 8'h92;
              exp_m  = exp_m || (h == 1);
            end else begin
              exp_st = (mp == 0 || h == 1) ? 8'h80 : 8'h92;
              exp_lk = (mp == 0 || h == 1);
            end
            if (s == 0) check("R7 supply status", status, exp_st);
            else if (km == 1) check("R5 master status", status, exp_st);
            else check("R4 block status", status, exp_st);
            check("R5 master bit", master, exp_m);
            qblk = 3'd2; #0.1;
            check("R4 target block", writable, !exp_lk);
            qblk = 3'd5; #0.1;
            check("R10 other block", writable, 1);
          end

    // R11 qualifiers sampled at confirm
    do_reset();
    hv = 1'b1; sup = 1'b1;
    wr(8'h00, 8'h60); wr(8'h00, 8'hF1);
    hv = 1'b0; sup = 1'b0;
    wait_idle();
    check("R11 master set despite drop", master, 1);
    check("R11 status", status, 8'h80);
    wr(blk_addr(6), 8'h60); wr(blk_addr(6), 8'h01);
    hv = 1'b1; sup = 1'b1;
    wait_idle();
    check("R11 failure kept", status, 8'h98);
    qblk = 3'd6; #0.1;
    check("R11 block unlocked", writable, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule